// File: doc/BRIEF.md
# Serial PHY Management Master

This block carries register reads and writes from a host controller to an external transceiver over a two-wire management link. One wire is a clock (`mdc`) that the block produces with a parameterised divider. The other is a shared data line, driven through `mdio_o`/`mdio_oe` and read back on `mdio_i`. The host presents a 6-bit transceiver address, a 5-bit register number, write data and a one-cycle start pulse. It receives read data and a one-cycle completion pulse. While an operation is in flight, `busy` stays high.

Every serial operation opens with a synchronisation run of ones. A write then shifts out a 32-bit frame and ends with two clocks that leave the line undriven. A read shifts out a 16-bit command and then releases the line. After that it samples a fixed window of 19 bits: two turnaround bits, 16 data bits and one trailing idle bit. The data is taken from the middle 16 bits of that window.

When the address is above 31, the serial link is not used. The access goes to a local register port instead, but only for register numbers that a parameter mask marks as mapped. Any other register number reads as zero, and a write to it is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `rsp_done`, `mdc`, `mdio_oe`, `loc_we`, `loc_re` and `rsp_rdata` are all 0.
- R2: Each serial bit slot lasts 2*DIV_HALF clock cycles. `mdc` is low for the first DIV_HALF cycles of the slot and high for the rest. `mdc` stays low when no serial operation is running. `mdio_o` changes only while `mdc` is low.
- R3: Every serial operation begins with PREAMBLE_SLOTS (default 32) slots in which `mdio_oe`=1 and `mdio_o`=1.
- R4: A write then drives 32 bits, most significant first. The frame is {01, 01, phy[4:0], reg[4:0], 10, wdata[15:0]}.
- R5: After the write frame, two more slots are clocked with `mdio_oe`=0. Completion follows after PREAMBLE_SLOTS+34 slots.
- R6: A read drives 16 command bits, most significant first. The command is {11, 01, 10, phy[4:0], reg[4:0]}. After that the line is released.
- R7: A read samples `mdio_i` on the last low cycle of each of the 19 slots that follow the command. The first sample is bit 18 and the last is bit 0. `rsp_rdata` becomes bits 16..1 of these samples when `rsp_done` pulses, after PREAMBLE_SLOTS+35 slots.
- R8: An operation is accepted only when `req_start`=1 and `busy`=0. `busy` stays high from the cycle after acceptance until `rsp_done`. `rsp_done` is a one-cycle pulse, and `busy` is low in that same cycle. A start while busy is ignored.
- R9: If phy[5]=1 and the register number is below 8 with its LOCAL_MASK bit set (default 8'h3F, registers 0..5), then for one cycle after acceptance `loc_we` (write) or `loc_re` (read) is high. In that cycle `loc_idx` = reg[2:0] and `loc_wdata` = wdata. `rsp_done` follows in the next cycle, and a read returns `loc_rdata` as it was during that cycle. No serial activity takes place.
- R10: If phy[5]=1 and the register is unmapped or is 8 or higher, neither `loc_we` nor `loc_re` rises. A read completes with `rsp_rdata`=0, and both reads and writes complete one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start pulse for one operation |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 6 | Transceiver address; bit 5 selects the local port |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read result, valid from `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |
| loc_we | output | 1 | Local register write strobe |
| loc_re | output | 1 | Local register read strobe |
| loc_idx | output | 3 | Local register index |
| loc_wdata | output | 16 | Local register write data |
| loc_rdata | input | 16 | Local register read data |

## Verification
Writes are exercised with an irregular data word, with all-zero data and with all-one address fields. Together these show whether the frame bits are placed and ordered correctly, and whether the released trailer follows them. Reads use alternating, asymmetric and all-one response patterns. The bench drives each response bit only in the last low cycle of its slot and drives the inverse in the other cycles, so sampling in any other cycle, or taking the wrong 16-bit window, gives a different result. Local accesses cover mapped registers, an unmapped register below 8 and a register number of 8 or above. A start pulsed in the middle of a serial operation shows whether the busy lockout holds.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

   typedef enum logic [1:0] {
      MDM_IDLE   = 2'd0,
      MDM_SERIAL = 2'd1,
      MDM_LOCAL  = 2'd2
   } mdm_state_e;

   localparam int WR_FRAME_BITS = 32;
   localparam int RD_CMD_BITS   = 16;
   localparam int RD_CAP_BITS   = 19;
   localparam int WR_TAIL_SLOTS = 2;
   localparam int LOCAL_REGS    = 8;

   function automatic logic [31:0] mdm_wr_word(input logic [4:0] phy,
                                               input logic [4:0] rg,
                                               input logic [15:0] dat);
      return {2'b01, 2'b01, phy, rg, 2'b10, dat};
   endfunction

   function automatic logic [15:0] mdm_rd_word(input logic [4:0] phy,
                                               input logic [4:0] rg);
      return {2'b11, 2'b01, 2'b10, phy, rg};
   endfunction

endpackage

// File: rtl/mdm_phase_gen.sv
module mdm_phase_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc_hi,
   output logic sample_now,
   output logic slot_end
);
   localparam int PERIOD = 2 * DIV_HALF;
   localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   generate
      if (DIV_HALF == 1) begin : g_toggle
         logic ph;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) ph <= 1'b0;
            else                ph <= ~ph;
         end
         assign mdc_hi     = run & ph;
         assign sample_now = run & ~ph;
         assign slot_end   = run & ph;
      end else begin : g_count
         logic [PH_W-1:0] ph;
         always_ff @(posedge clk) begin
            if (!rst_n || !run)                     ph <= '0;
            else if (ph == PH_W'(PERIOD - 1))       ph <= '0;
            else                                    ph <= ph + 1'b1;
         end
         assign mdc_hi     = run && (ph >= PH_W'(DIV_HALF));
         assign sample_now = run && (ph == PH_W'(DIV_HALF - 1));
         assign slot_end   = run && (ph == PH_W'(PERIOD - 1));
      end
   endgenerate

endmodule

// File: rtl/mdm_shifter.sv
module mdm_shifter #(
   parameter int TX_W  = 64,
   parameter int CAP_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TX_W-1:0]  load_word,
   input  logic             adv,
   input  logic             cap,
   input  logic             mdio_i,
   output logic             tx_bit,
   output logic [15:0]      rx_data
);
   logic [TX_W-1:0]  tx_sr;
   logic [CAP_W-1:0] rx_sr;
   logic             unused_rx_edges;

   always_ff @(posedge clk) begin
      if (!rst_n)     tx_sr <= '0;
      else if (load)  tx_sr <= load_word;
      else if (adv)   tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rx_sr <= '0;
      else if (load)  rx_sr <= '0;
      else if (cap)   rx_sr <= {rx_sr[CAP_W-2:0], mdio_i};
   end

   assign tx_bit          = tx_sr[TX_W-1];
   assign rx_data         = rx_sr[16:1];
   assign unused_rx_edges = ^{rx_sr[CAP_W-1:17], rx_sr[0]};

endmodule

// File: rtl/mdm_local_map.sv
module mdm_local_map #(
   parameter logic [7:0] LOCAL_MASK = 8'h3F
) (
   input  logic [4:0] reg_addr,
   output logic       hit
);
   generate
      if (LOCAL_MASK == 8'h00) begin : g_none
         logic unused_addr;
         assign unused_addr = ^reg_addr;
         assign hit = 1'b0;
      end else begin : g_mask
         assign hit = (reg_addr[4:3] == 2'b00) && LOCAL_MASK[reg_addr[2:0]];
      end
   endgenerate
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdm_pkg::*;
#(
   parameter int         DIV_HALF       = 2,
   parameter int         PREAMBLE_SLOTS = 32,
   parameter logic [7:0] LOCAL_MASK     = 8'h3F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_start,
   input  logic        req_write,
   input  logic [5:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   output logic [15:0] rsp_rdata,
   output logic        rsp_done,
   output logic        busy,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i,
   output logic        loc_we,
   output logic        loc_re,
   output logic [2:0]  loc_idx,
   output logic [15:0] loc_wdata,
   input  logic [15:0] loc_rdata
);
   localparam int TX_W      = PREAMBLE_SLOTS + WR_FRAME_BITS;
   localparam int WR_DRIVE  = PREAMBLE_SLOTS + WR_FRAME_BITS;
   localparam int RD_DRIVE  = PREAMBLE_SLOTS + RD_CMD_BITS;
   localparam int WR_SLOTS  = WR_DRIVE + WR_TAIL_SLOTS;
   localparam int RD_SLOTS  = RD_DRIVE + RD_CAP_BITS;
   localparam int MAX_SLOTS = (WR_SLOTS > RD_SLOTS) ? WR_SLOTS : RD_SLOTS;
   localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PREAMBLE_SLOTS < 1) begin : g_bad_pre
         $error("PREAMBLE_SLOTS must be at least 1");
      end
   endgenerate

   mdm_state_e        state_q;
   logic [SLOT_W-1:0] slot_q;
   logic              op_write_q;
   logic [2:0]        op_idx_q;
   logic [15:0]       op_wdata_q;
   logic [15:0]       rdata_q;
   logic              done_q;
   logic              loc_we_q;
   logic              loc_re_q;

   logic              run, accept, map_hit;
   logic              mdc_hi, sample_now, slot_end;
   logic              tx_bit, cap_en, drive_en;
   logic [15:0]       rx_data;
   logic [TX_W-1:0]   load_word;
   logic [SLOT_W-1:0] last_slot;

   assign run       = (state_q == MDM_SERIAL);
   assign accept    = req_start && (state_q == MDM_IDLE);
   assign last_slot = op_write_q ? SLOT_W'(WR_SLOTS - 1) : SLOT_W'(RD_SLOTS - 1);

   always_comb begin
      if (req_write)
         load_word = {{PREAMBLE_SLOTS{1'b1}}, mdm_wr_word(req_phy[4:0], req_reg, req_wdata)};
      else
         load_word = {{PREAMBLE_SLOTS{1'b1}}, mdm_rd_word(req_phy[4:0], req_reg), 16'h0000};
   end

   mdm_phase_gen #(.DIV_HALF(DIV_HALF)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .mdc_hi     (mdc_hi),
      .sample_now (sample_now),
      .slot_end   (slot_end)
   );

   assign cap_en   = sample_now && !op_write_q && (slot_q >= SLOT_W'(RD_DRIVE));
   assign drive_en = run && (op_write_q ? (slot_q < SLOT_W'(WR_DRIVE))
                                        : (slot_q < SLOT_W'(RD_DRIVE)));

   mdm_shifter #(.TX_W(TX_W), .CAP_W(RD_CAP_BITS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && !req_phy[5]),
      .load_word (load_word),
      .adv       (slot_end),
      .cap       (cap_en),
      .mdio_i    (mdio_i),
      .tx_bit    (tx_bit),
      .rx_data   (rx_data)
   );

   mdm_local_map #(.LOCAL_MASK(LOCAL_MASK)) u_map (
      .reg_addr (req_reg),
      .hit      (map_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= MDM_IDLE;
         slot_q     <= '0;
         op_write_q <= 1'b0;
         op_idx_q   <= '0;
         op_wdata_q <= '0;
         rdata_q    <= '0;
         done_q     <= 1'b0;
         loc_we_q   <= 1'b0;
         loc_re_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            MDM_IDLE: begin
               if (accept) begin
                  op_write_q <= req_write;
                  op_idx_q   <= req_reg[2:0];
                  op_wdata_q <= req_wdata;
                  slot_q     <= '0;
                  if (req_phy[5]) begin
                     state_q  <= MDM_LOCAL;
                     loc_we_q <= req_write & map_hit;
                     loc_re_q <= ~req_write & map_hit;
                  end else begin
                     state_q  <= MDM_SERIAL;
                  end
               end
            end
            MDM_LOCAL: begin
               state_q  <= MDM_IDLE;
               done_q   <= 1'b1;
               loc_we_q <= 1'b0;
               loc_re_q <= 1'b0;
               if (!op_write_q) rdata_q <= loc_re_q ? loc_rdata : 16'h0000;
            end
            MDM_SERIAL: begin
               if (slot_end) begin
                  if (slot_q == last_slot) begin
                     state_q <= MDM_IDLE;
                     done_q  <= 1'b1;
                     if (!op_write_q) rdata_q <= rx_data;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end
            end
            default: state_q <= MDM_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != MDM_IDLE);
   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;
   assign mdc       = mdc_hi;
   assign mdio_oe   = drive_en;
   assign mdio_o    = drive_en & tx_bit;
   assign loc_we    = loc_we_q;
   assign loc_re    = loc_re_q;
   assign loc_idx   = op_idx_q;
   assign loc_wdata = op_wdata_q;

endmodule

// File: rtl/mdm_checker.sv
module mdm_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic rsp_done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe,
   input logic loc_we,
   input logic loc_re
);
   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc); // R2
   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o)); // R2
   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R8
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!busy && $past(busy))); // R8
   AST_LOC_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_we, loc_re})); // R9
   AST_LOC_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_we || loc_re) |-> (!mdio_oe && !mdc && busy)); // R9
   AST_LOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_we || loc_re) |=> (rsp_done && !loc_we && !loc_re)); // R9
endmodule

bind mdio_mgmt_master mdm_checker i_mdm_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rsp_done (rsp_done),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .loc_we   (loc_we),
   .loc_re   (loc_re)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0, req_write = 1'b0;
   logic [5:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata, loc_wdata;
   logic        rsp_done, busy, mdc, mdio_o, mdio_oe, loc_we, loc_re;
   logic [2:0]  loc_idx;
   logic        mdio_i = 1'b1;
   logic [15:0] loc_rdata = '0;

   int vectors = 0, misses = 0;
   bit check_on = 1'b0;

   always #2.5 clk = ~clk;

   mdio_mgmt_master #(.DIV_HALF(DIV), .PREAMBLE_SLOTS(32), .LOCAL_MASK(8'h3F)) i_mdio_mgmt_master (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .busy(busy), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
      .loc_we(loc_we), .loc_re(loc_re), .loc_idx(loc_idx),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata));

   // reference model state
   bit          m_busy = 0, m_done = 0, m_local = 0, m_write = 0, m_hit = 0;
   int          m_cyc = 0, m_total = 0, m_reg = 0;
   logic [15:0] m_wdata = '0, m_rdata = '0, m_cmd = '0;
   logic [31:0] m_frame = '0;
   logic [18:0] m_resp = '0, resp_next = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cyc = 0; m_rdata = '0; m_local = 0; m_hit = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cyc++;
            if (m_cyc == m_total) begin
               m_busy = 0; m_done = 1;
               if (!m_write)
                  m_rdata = m_local ? (m_hit ? (16'h9000 | 16'(m_reg)) : 16'h0000) : m_resp[16:1];
            end
         end else if (req_start) begin
            m_busy  = 1; m_cyc = 0;
            m_write = req_write; m_reg = int'(req_reg); m_wdata = req_wdata;
            m_local = req_phy > 6'd31;
            m_hit   = (m_reg < 6) ? 1'b1 : 1'b0;
            m_resp  = resp_next;
            m_frame = {2'b01, 2'b01, req_phy[4:0], req_reg, 2'b10, req_wdata};
            m_cmd   = {2'b11, 2'b01, 2'b10, req_phy[4:0], req_reg};
            m_total = m_local ? 1 : (m_write ? 66 : 67) * 2 * DIV;
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp,
                      input string what);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      int slot, ph, rb;
      bit ser;
      logic eoe, eo;
      string t, lt;
      ser  = m_busy && !m_local;
      slot = m_cyc / (2 * DIV);
      ph   = m_cyc % (2 * DIV);
      if (check_on) begin
         chk("R8", busy, m_busy, "busy");
         chk("R8", rsp_done, m_done, "done");
         chk("R2", mdc, ser && ph >= DIV, "mdc");
         eoe = 0; eo = 0; t = "R8";
         if (ser) begin
            if (slot < 32) begin t = "R3"; eoe = 1; eo = 1; end
            else if (m_write) begin
               if (slot < 64) begin t = "R4"; eoe = 1; eo = m_frame[63 - slot]; end
               else t = "R5";
            end else begin
               if (slot < 48) begin t = "R6"; eoe = 1; eo = m_cmd[47 - slot]; end
               else t = "R7";
            end
         end
         chk(t, mdio_oe, eoe, "mdio_oe");
         if (eoe) chk(t, mdio_o, eo, "mdio_o");
         lt = m_hit ? "R9" : "R10";
         chk(lt, loc_we, m_busy && m_local && m_write && m_hit, "loc_we");
         chk(lt, loc_re, m_busy && m_local && !m_write && m_hit, "loc_re");
         if (loc_we || loc_re) chk("R9", loc_idx, m_reg[2:0], "loc_idx");
         if (loc_we) chk("R9", loc_wdata, m_wdata, "loc_wdata");
         if (m_done) chk(m_local ? lt : "R7", rsp_rdata, m_rdata, "rdata");
      end
      // response drive: correct bit only on the last low cycle of a slot
      if (ser && !m_write && slot >= 48 && slot < 67) begin
         rb = 18 - (slot - 48);
         mdio_i = (ph == DIV - 1) ? m_resp[rb] : ~m_resp[rb];
      end else begin
         mdio_i = 1'b1;
      end
      loc_rdata = 16'h9000 | 16'(m_reg);
   end

   task automatic do_op(input bit wr, input int phy, input int rg, input logic [15:0] wd,
                        input logic [18:0] resp, input bit poke);
      @(negedge clk);
      req_start = 1; req_write = wr; req_phy = phy[5:0]; req_reg = rg[4:0];
      req_wdata = wd; resp_next = resp;
      @(negedge clk);
      req_start = 0;
      if (poke) begin
         repeat (40) @(negedge clk);
         req_start = 1; req_write = ~wr; req_phy = 6'd40; req_reg = 5'd1; req_wdata = 16'h1111;
         @(negedge clk);
         req_start = 0;
      end
      while (!m_done) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs idle under reset
      chk("R1", {busy, rsp_done, mdc, mdio_oe, loc_we, loc_re}, '0, "idle outputs in reset");
      chk("R1", rsp_rdata, 16'h0000, "rdata in reset");
      rst_n = 1;
      @(negedge clk);
      chk("R1", {busy, rsp_done, mdc, mdio_oe}, '0, "idle outputs after reset");
      check_on = 1;
      do_op(1, 5, 17, 16'hA53C, '0, 0);            // R4 R5 write, mixed data
      do_op(0, 1, 2, 16'h0, 19'h5A3C7, 0);         // R6 R7 read, asymmetric pattern
      do_op(0, 9, 30, 16'h0, 19'h2AAAA, 0);        // R7 alternating
      do_op(1, 31, 31, 16'h0000, '0, 0);           // R4 all-one addresses, zero data
      do_op(0, 31, 0, 16'h0, 19'h7FFFF, 1);        // R8 start while busy ignored
      do_op(1, 0, 0, 16'hFFFF, '0, 1);             // R8 during write
      do_op(1, 32, 2, 16'hBEEF, '0, 0);            // R9 local write
      do_op(0, 33, 3, 16'h0, '0, 0);               // R9 local read
      do_op(0, 63, 0, 16'h0, '0, 0);               // R9 register 0
      do_op(0, 40, 6, 16'h0, '0, 0);               // R10 unmapped read -> 0
      do_op(1, 40, 7, 16'h4242, '0, 0);            // R10 unmapped write dropped
      do_op(0, 48, 12, 16'h0, '0, 0);              // R10 register >= 8 reads 0
      do_op(1, 48, 20, 16'h7777, '0, 0);           // R10 register >= 8 write dropped
      do_op(0, 7, 21, 16'h0, 19'h00001, 0);        // R7 trailing idle bit discarded
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL R8 watchdog expired: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule